// File: doc/BRIEF.md
# Machine Clock Mode Controller

This block picks the machine clock for a chip from one of two sources: the oscillator divided by two (main mode) or an externally generated PLL clock. Here the PLL clock is modelled as a per-cycle enable input. Software drives the choice through one control byte on a simple write/read port. The byte holds three fields. The first is a mode-select bit. The second is a read-only mode-monitor bit that shows which source is actually in use. The third is a three-bit multiplier code, which the block only decodes into a ratio output.

The switch to PLL mode is never immediate. Clearing the select bit starts a fixed wait of 2^WAIT_LOG2 oscillator cycles, so the PLL can settle. While the wait runs, the machine clock stays on the divided main clock. When the wait ends, the monitor bit drops and the PLL enable takes over. The same write that starts the wait also sends a one-cycle clear pulse to an external time-base timer, which clears that timer's count and overflow flag. Setting the select bit returns to main mode at once.

Top module: `mclk_mode_ctrl`

## Requirements
- R1: After reset the control byte reads 0x03 (select 1, monitor 1, code 000), `ratio_o` is 1 and `tb_clr_o` is 0.
- R2: Read layout: bit 0 is select, bit 1 is monitor, bits 4:2 are the multiplier code, and bits 7:5 read 0. A write takes effect in the cycle after its clock edge.
- R3: A write with bit 0 = 0 while select is 1 starts the wait. `tb_clr_o` is then 1 for exactly the one cycle after the write edge. Select reads 0 and monitor still reads 1.
- R4: Monitor falls to 0 exactly 2^WAIT_LOG2 clock edges after the starting write edge, and not before.
- R5: While monitor is 1, `mclk_en_o` is high on every second cycle, giving half the oscillator rate.
- R6: While monitor is 0, `mclk_en_o` equals `pll_tick_i`.
- R7: A write with bit 0 = 0 while select is already 0 produces no clear pulse and does not restart the wait.
- R8: A write with bit 0 = 1 while select is 0 makes select and monitor read 1 in the next cycle. It cancels any running wait and produces no clear pulse.
- R9: Code bits in a write are discarded unless select and monitor are both 1 before that write.
- R10: `ratio_o` decodes the code: 000..011 give 1, 2, 3, 4, and 100..111 give 2, 4, 6, 8.
- R11: Bit 1 of a write has no effect on the monitor bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data |
| rd_data_o | output | 8 | Control byte read data |
| pll_tick_i | input | 1 | PLL clock enable from the external PLL model |
| mclk_en_o | output | 1 | Machine clock enable |
| tb_clr_o | output | 1 | One-cycle clear to the time-base timer |
| ratio_o | output | 4 | Decoded PLL multiplier |

## Verification
The assertions check the following on every cycle:
- the clear pulse lasts a single cycle;
- the monitor never reads 0 while select reads 1;
- the code holds still under a gated write;
- the enable alternates in main mode;
- high-range codes decode to even ratios.

Some behaviours can only be shown by the bench's scenarios. These include the exact length of the wait, the rule that a repeated 0 write does not restart the wait, the abort that keeps the monitor at 1 long after the wait would have ended, and the full decode table.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  typedef enum logic [0:0] {SRC_PLL = 1'b0, SRC_MAIN = 1'b1} mclk_src_e;

  // low range: code+1, high range: 2*(code[1:0]+1)
  function automatic logic [3:0] decode_ratio(input logic [2:0] code);
    logic [3:0] base;
    base = {2'b00, code[1:0]} + 4'd1;
    return code[2] ? (base << 1) : base;
  endfunction
endpackage

// File: rtl/mclk_wait_ctr.sv
module mclk_wait_ctr #(
  parameter int WAIT_LOG2 = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [WAIT_LOG2-1:0] CNT_MAX = '1;

  logic [WAIT_LOG2-1:0] cnt_q;
  logic                 busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_MAX) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_MAX) busy_q <= 1'b0;
      else                  cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R4: a freshly started wait begins from zero
  a_r4_start_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/mclk_en_mux.sv
module mclk_en_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic main_i,
  input  logic pll_tick_i,
  output logic mclk_en_o
);
  logic div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= ~div_q;
  end

  assign mclk_en_o = main_i ? div_q : pll_tick_i;

  // R5: no two back-to-back enables while on the divided main clock
  a_r5_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_i && mclk_en_o) |=> (!main_i || !mclk_en_o));
endmodule

// File: rtl/mclk_mode_ctrl.sv
module mclk_mode_ctrl #(
  parameter int WAIT_LOG2 = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       pll_tick_i,
  output logic       mclk_en_o,
  output logic       tb_clr_o,
  output logic [3:0] ratio_o
);
  import mclk_pkg::*;

  mclk_src_e  sel_q;
  logic       mon_q;
  logic [2:0] code_q;
  logic       clr_q;
  logic       start, abort, code_we, wait_done, wait_busy;
  logic       wr_sel;

  assign wr_sel  = wr_data_i[0];
  assign start   = wr_en_i && (sel_q == SRC_MAIN) && !wr_sel;
  assign abort   = wr_en_i && (sel_q == SRC_PLL) && wr_sel;
  assign code_we = wr_en_i && (sel_q == SRC_MAIN) && mon_q;

  mclk_wait_ctr #(.WAIT_LOG2(WAIT_LOG2)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (abort),
    .busy_o  (wait_busy),
    .done_o  (wait_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SRC_MAIN;
      mon_q  <= 1'b1;
      code_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= start;
      if (wr_en_i) sel_q <= wr_sel ? SRC_MAIN : SRC_PLL;
      if (code_we) code_q <= wr_data_i[4:2];
      if (abort)          mon_q <= 1'b1;
      else if (wait_done) mon_q <= 1'b0;
    end
  end

  mclk_en_mux u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .main_i     (mon_q),
    .pll_tick_i (pll_tick_i),
    .mclk_en_o  (mclk_en_o)
  );

  assign rd_data_o = {3'b000, code_q, mon_q, sel_q == SRC_MAIN};
  assign tb_clr_o  = clr_q;
  assign ratio_o   = decode_ratio(code_q);

  a_r3_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_clr_o |=> !tb_clr_o);
  a_r4_pll_needs_sel0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_q |-> (sel_q == SRC_PLL));
  a_r4_wait_keeps_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_busy |-> mon_q);
  a_r9_code_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !((sel_q == SRC_MAIN) && mon_q)) |=> $stable(code_q));
  a_r10_high_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q[2] |-> (ratio_o[0] == 1'b0 && ratio_o != 4'd0));
endmodule

// File: tb/mclk_mode_ctrl_test.sv
module mclk_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LOG2  = 14;
  localparam int WAIT_CYC   = 1 << WAIT_LOG2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       pll_tick = 1'b0;
  logic       mclk_en, tb_clr;
  logic [3:0] ratio;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mclk_mode_ctrl #(.WAIT_LOG2(WAIT_LOG2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pll_tick_i(pll_tick), .mclk_en_o(mclk_en),
    .tb_clr_o(tb_clr), .ratio_o(ratio)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ones, prev;
    @(negedge clk); @(negedge clk);
    check("R1 rd", rd_data, 8'h03);
    check("R1 ratio", ratio, 1);
    check("R1 clr", tb_clr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10/R2 sweep
    for (int c = 0; c < 8; c++) begin
      wr({3'b000, c[2:0], 2'b11});
      check("R2 rd", rd_data, {3'b000, c[2:0], 2'b11});
      check("R10 ratio", ratio, (c < 4) ? c + 1 : (c - 3) * 2);
    end

    // R11: monitor bit ignores writes
    wr(8'h01);
    check("R11 mon", rd_data, 8'h03);

    // R5
    ones = 0; prev = mclk_en;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ones += mclk_en;
      check("R5 alt", mclk_en, !prev);
      prev = mclk_en;
    end
    check("R5 count", ones, 10);

    // R3: start wait with code 3
    wr(8'h0F);
    wr(8'h0C);
    check("R3 clr", tb_clr, 1);
    check("R3 rd", rd_data, 8'h0E);
    @(negedge clk);
    check("R3 clr single", tb_clr, 0);
    // R9 during wait (negedge 2 after start)
    wr(8'h14);
    check("R9 wait", rd_data, 8'h0E);
    // R7 repeat write 0 (ends at negedge 3)
    wr(8'h00);
    check("R7 clr", tb_clr, 0);
    repeat (WAIT_CYC - 1 - 3) @(negedge clk);
    check("R4 before", rd_data[1], 1);
    check("R7 no restart", rd_data[1], 1);
    @(negedge clk);
    check("R4 fall", rd_data[1], 0);
    check("R4 rd", rd_data, 8'h0C);

    // R9 in PLL mode
    wr(8'h1C);
    check("R9 pll", rd_data, 8'h0C);
    check("R9 ratio", ratio, 4);

    // R6
    for (int i = 0; i < 16; i++) begin
      pll_tick = i[0] ^ i[2];
      #1;
      check("R6 follow", mclk_en, pll_tick);
      @(negedge clk);
    end
    pll_tick = 1'b0;

    // R8 from PLL mode
    wr(8'h01);
    check("R8 rd", rd_data, 8'h0F);
    check("R8 clr", tb_clr, 0);

    // R8 abort running wait
    wr(8'h0C);
    repeat (50) @(negedge clk);
    wr(8'h0D);
    check("R8 abort rd", rd_data, 8'h0F);
    check("R8 abort clr", tb_clr, 0);
    repeat (WAIT_CYC + 5) @(negedge clk);
    check("R8 stays main", rd_data, 8'h0F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule